// File: doc/BRIEF.md
# Register-Bank I2C Target

This block is an I2C target (slave) that presents a small bank of 8-bit registers to a bus controller. It watches the open-drain clock and data lines, synchronises both to the system clock, and recognises START, repeated START and STOP conditions. Each transaction opens with an address byte. When the upper seven bits equal the block's own address, it acknowledges and then either receives or sends bytes, depending on the direction bit.

The first byte written after the address loads an 8-bit register pointer. Each later written byte is stored at the pointer, and the pointer then advances. A read begins at the pointer left by the earlier write phase, which is usually reached through a repeated START, and every further byte comes from the next index. Index 0 is a read-only identification register that always returns 0x81. Index 1 is a read-only view of a status input. The remaining implemented indices are writable, and their contents drive an output bus for the surrounding logic. Indices past the implemented bank read back zero.

The block only ever pulls the data line low or lets it go: `sda_oe` high means "drive SDA low". It never stretches the clock.

Top module: `i2c_regbank_slave`

## Requirements
- R1: An address byte whose bits 7..1 equal OWN_ADDR (default 7'h42) is acknowledged by pulling SDA low for the ninth clock. Any other address gets no acknowledge, SDA stays released for the rest of that transaction, and no register changes.
- R2: In a write (address bit 0 = 0), the first data byte loads the register pointer. Each following byte is stored at the pointer, and the pointer then increments. Every data byte is acknowledged.
- R3: In a read (address bit 0 = 1), the first byte returned is the register at the current pointer, and each further byte is the next index. The pointer survives a repeated START.
- R4: A START seen at any bit position, including in the middle of a byte, releases SDA and restarts address reception. A partially received byte is discarded, and the pointer is kept.
- R5: While sending, the block goes on to the next byte after a master ACK. After a master NACK it keeps SDA released until the next START or STOP, whatever the master clocks. A STOP always releases SDA.
- R6: Index 0 reads 0x81 and index 1 reads the `status_i` input. Writes to both are acknowledged and leave the read value unchanged.
- R7: Indices NUM_REGS (default 8) through 255 read 0x00. Writes to them are acknowledged and discarded.
- R8: The pointer wraps from 255 to 0 when it increments.
- R9: Bits move MSB first. Received bits are sampled on the synchronised SCL rising edge, and `sda_oe` changes only while the synchronised SCL is low, except when a START or STOP releases it.
- R10: After reset, `sda_oe` is 0 and every writable register is 0x00.
- R11: Writable register k (k >= 2) appears on `wr_regs_o[(k-2)*8 +: 8]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| status_i | input | 8 | Value returned by read-only index 1 |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release SDA |
| wr_regs_o | output | (NUM_REGS-2)*8 | Contents of the writable registers, index 2 in the low byte |

## Verification
The hardest case to reach from the ports is a repeated START that lands partway through a data byte. The target must then drop the half-shifted byte, keep its pointer and decode a fresh address. The bench drives three data bits of a write, raises a repeated START while SCL is high, and reads back the register that the partial byte would have overwritten. A second hard case is the released state after a master NACK. There the bench keeps clocking the bus without a STOP and checks on every clock that the line stays high. Pointer wrap is reached by loading index 0xFE and reading four bytes in one burst.

// File: rtl/i2c_slv_pkg.sv
// Package: shared types and fixed indices for the register-bank I2C target.
// Assumes the read-only registers sit at the lowest indices of the bank.
package i2c_slv_pkg;

    // Protocol phase of the target
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // no transaction addressed to anyone yet
        ST_ADDR  = 3'd1,   // shifting in the address byte
        ST_WRITE = 3'd2,   // receiving pointer / data bytes
        ST_READ  = 3'd3,   // sending data bytes
        ST_HOLD  = 3'd4    // not selected or NACKed: silent until START/STOP
    } slv_state_e;

    localparam int NUM_RO   = 2;       // read-only registers at the bottom of the bank
    localparam int IDX_ID   = 0;       // identification register
    localparam int IDX_STAT = 1;       // status mirror register
    localparam logic [7:0] ID_VALUE = 8'h81;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings SCL and SDA into the clock domain through a STAGES-deep flip-flop
// chain and derives SCL edges and START/STOP conditions from the synchronised
// copies. Assumes the bus is much slower than clk (several clocks per SCL phase).
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Synchroniser chains and one-cycle history; idle bus level is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    // Edge and condition decode on the synchronised lines
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_reg_file.sv
// Module: i2c_reg_file
// Register bank behind the target. The lowest indices are read-only
// (identification constant, status mirror). The rest are writable flops.
// Any index at or above NUM_REGS reads zero and ignores writes.
module i2c_reg_file
    import i2c_slv_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int PTR_W    = 8,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int WR_W    = (NUM_REGS - NUM_RO) * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [7:0]       rdata,
    input  logic [7:0]       status_i,
    output logic [WR_W-1:0]  wr_regs_o
);

    logic [7:0] bank [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == IDX_ID) begin : g_id
            assign bank[i] = ID_VALUE;
        end else if (i == IDX_STAT) begin : g_stat
            assign bank[i] = status_i;
        end else begin : g_rw
            logic [7:0] q;
            // Storage for one writable register
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= 8'h00;
                end else if (we && (waddr == PTR_W'(i))) begin
                    q <= wdata;
                end
            end
            assign bank[i] = q;
            assign wr_regs_o[(i-NUM_RO)*8 +: 8] = q;
        end
    end

    // Read mux with zero for indices outside the bank
    always_comb begin
        if ({1'b0, raddr} < (PTR_W+1)'(NUM_REGS)) begin
            rdata = bank[raddr[IDX_W-1:0]];
        end else begin
            rdata = 8'h00;
        end
    end

endmodule

// File: rtl/i2c_slv_fsm.sv
// Module: i2c_slv_fsm
// Bit- and byte-level protocol engine of the target. It counts SCL rising edges
// within each 9-clock byte frame, samples on rises, and changes the SDA drive
// only on falls. Assumes synchronised, edge-decoded lines from i2c_line_sync.
module i2c_slv_fsm
    import i2c_slv_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR = 7'h42,
    parameter int         PTR_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rdata,
    output logic [PTR_W-1:0] ptr,
    output logic             we,
    output logic [PTR_W-1:0] waddr,
    output logic [7:0]       wdata,
    output logic             sda_oe,
    output slv_state_e       state
);

    localparam logic [3:0] ACK_POS = 4'd8;   // rises seen when the ACK slot opens
    localparam logic [3:0] END_POS = 4'd9;   // rises seen when the frame ends

    logic [3:0] bit_cnt;      // SCL rises seen in the current frame
    logic [7:0] rx_sr;        // incoming byte, MSB first
    logic [6:0] tx_sr;        // outgoing bits still to be shown
    logic       dir_rd;       // latched direction bit
    logic       ptr_pend;     // next written byte is the pointer
    logic       mst_ack;      // master acknowledged the last sent byte

    // Commit a received data byte at the start of its ACK slot
    always_comb begin
        we    = (state == ST_WRITE) && scl_fall && (bit_cnt == ACK_POS) && !ptr_pend;
        waddr = ptr;
        wdata = rx_sr;
    end

    // Protocol sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            dir_rd   <= 1'b0;
            ptr_pend <= 1'b0;
            mst_ack  <= 1'b0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
        end else if (start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        if (bit_cnt < ACK_POS) rx_sr <= {rx_sr[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bit_cnt == ACK_POS) begin
                            if (rx_sr[7:1] == OWN_ADDR) begin
                                sda_oe <= 1'b1;
                                dir_rd <= rx_sr[0];
                            end else begin
                                state <= ST_HOLD;
                            end
                        end else if (bit_cnt == END_POS) begin
                            bit_cnt <= '0;
                            if (dir_rd) begin
                                state  <= ST_READ;
                                tx_sr  <= rdata[6:0];
                                sda_oe <= ~rdata[7];
                                ptr    <= ptr + 1'b1;
                            end else begin
                                state    <= ST_WRITE;
                                ptr_pend <= 1'b1;
                                sda_oe   <= 1'b0;
                            end
                        end
                    end
                end
                ST_WRITE: begin
                    if (scl_rise) begin
                        if (bit_cnt < ACK_POS) rx_sr <= {rx_sr[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bit_cnt == ACK_POS) begin
                            sda_oe <= 1'b1;
                            if (ptr_pend) begin
                                ptr      <= rx_sr;
                                ptr_pend <= 1'b0;
                            end else begin
                                ptr <= ptr + 1'b1;
                            end
                        end else if (bit_cnt == END_POS) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                        end
                    end
                end
                ST_READ: begin
                    if (scl_rise) begin
                        if (bit_cnt == ACK_POS) mst_ack <= ~sda_s;
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (scl_fall) begin
                        if ((bit_cnt != 4'd0) && (bit_cnt < ACK_POS)) begin
                            sda_oe <= ~tx_sr[6];
                            tx_sr  <= {tx_sr[5:0], 1'b0};
                        end else if (bit_cnt == ACK_POS) begin
                            sda_oe <= 1'b0;
                        end else if (bit_cnt == END_POS) begin
                            bit_cnt <= '0;
                            if (mst_ack) begin
                                tx_sr  <= rdata[6:0];
                                sda_oe <= ~rdata[7];
                                ptr    <= ptr + 1'b1;
                            end else begin
                                state  <= ST_HOLD;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/i2c_regbank_slave.sv
// Module: i2c_regbank_slave
// Top of the register-bank I2C target: line synchroniser, protocol engine and
// register bank. sda_oe high means the pad must pull SDA low. Assumes SCL is
// never stretched and that the pads provide the pull-ups.
module i2c_regbank_slave
    import i2c_slv_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR    = 7'h42,
    parameter int         NUM_REGS    = 8,
    parameter int         SYNC_STAGES = 2,
    localparam int        PTR_W       = 8,
    localparam int        WR_W        = (NUM_REGS - NUM_RO) * 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    input  logic [7:0]      status_i,
    output logic            sda_oe,
    output logic [WR_W-1:0] wr_regs_o
);

    logic             scl_s;
    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic [PTR_W-1:0] ptr;
    logic             we;
    logic [PTR_W-1:0] waddr;
    logic [7:0]       wdata;
    logic [7:0]       rdata;
    slv_state_e       fsm_state;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_slv_fsm #(.OWN_ADDR(OWN_ADDR), .PTR_W(PTR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rdata     (rdata),
        .ptr       (ptr),
        .we        (we),
        .waddr     (waddr),
        .wdata     (wdata),
        .sda_oe    (sda_oe),
        .state     (fsm_state)
    );

    i2c_reg_file #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (we),
        .waddr     (waddr),
        .wdata     (wdata),
        .raddr     (ptr),
        .rdata     (rdata),
        .status_i  (status_i),
        .wr_regs_o (wr_regs_o)
    );

endmodule

// File: rtl/i2c_slv_checker.sv
// Module: i2c_slv_checker
// Protocol properties of the register-bank I2C target, bound to its top.
module i2c_slv_checker
    import i2c_slv_pkg::*;
#(
    parameter int WR_W = 48
) (
    input logic            clk,
    input logic            rst_n,
    input logic            scl_s,
    input logic            start_det,
    input logic            stop_det,
    input logic            sda_oe,
    input slv_state_e      fsm_state,
    input logic [WR_W-1:0] wr_regs_o
);

    // R9: the drive changes only in the SCL low phase, or on a START/STOP release
    p_oe_moves_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

    // R5: a STOP always leaves SDA released
    p_stop_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R4: a START always leaves SDA released while the address is received
    p_start_releases_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R6: the writable bank does not move while bytes are being sent
    p_regs_quiet_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_READ) |=> $stable(wr_regs_o));

    // R1: SDA is driven only inside a transaction addressed to this target
    p_drive_only_selected_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> ((fsm_state != ST_IDLE) && (fsm_state != ST_HOLD)));

endmodule

bind i2c_regbank_slave i2c_slv_checker #(.WR_W(WR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .fsm_state (fsm_state),
    .wr_regs_o (wr_regs_o)
);

// File: tb/tb_i2c_regbank_slave.sv
// Bench: acts as a bus controller on a wired-AND model of SDA, walks a vector
// table of write-then-read-back cases, then runs directed corner cases.
module tb_i2c_regbank_slave;

    localparam logic [6:0] ADDR  = 7'h42;
    localparam int         NREG  = 8;
    localparam int         WR_W  = (NREG - 2) * 8;
    localparam int         Q     = 12;          // clocks per quarter bit
    localparam logic [7:0] STAT  = 8'h5C;

    // {index, value written, value expected on read-back}
    localparam logic [23:0] VEC [8] = '{
        {8'h02, 8'hA5, 8'hA5},
        {8'h07, 8'h3C, 8'h3C},
        {8'h00, 8'hFF, 8'h81},
        {8'h01, 8'h00, 8'h5C},
        {8'h05, 8'h81, 8'h81},
        {8'h08, 8'h77, 8'h00},
        {8'hFF, 8'h12, 8'h00},
        {8'h03, 8'h01, 8'h01}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            scl_m = 1'b1;
    logic            sda_m = 1'b1;
    logic            sda_line;
    logic            sda_oe;
    logic [WR_W-1:0] wr_regs;
    int              n_chk = 0;
    int              n_err = 0;
    bit              done  = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_regbank_slave #(.OWN_ADDR(ADDR), .NUM_REGS(NREG)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .status_i  (STAT),
        .sda_oe    (sda_oe),
        .wr_regs_o (wr_regs)
    );

    task automatic chk(input string tag, input logic [WR_W-1:0] act, input logic [WR_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic qw(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; qw(1);
        sda_m = 1'b0; qw(1);
        scl_m = 1'b0; qw(1);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; qw(1);
        scl_m = 1'b1; qw(1);
        sda_m = 1'b0; qw(1);
        scl_m = 1'b0; qw(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw(1);
        scl_m = 1'b1; qw(1);
        sda_m = 1'b1; qw(1);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; qw(1);
        scl_m = 1'b1; qw(2);
        scl_m = 1'b0; qw(1);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; qw(1);
        scl_m = 1'b1; qw(1);
        b = sda_line; qw(1);
        scl_m = 1'b0; qw(1);
    endtask

    // Returns the ACK bit: 0 = acknowledged
    task automatic put_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ack);
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(~give_ack);
    endtask

    function automatic logic [7:0] wreg(input logic [WR_W-1:0] bus, input int k);
        return bus[(k-2)*8 +: 8];
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic       a;
        logic       b;
        logic [7:0] d;
        logic [7:0] saved;
        logic       acks_bad;

        repeat (4) @(negedge clk);
        chk("R10 sda_oe in reset", {47'd0, sda_oe}, '0);
        rst_n = 1'b1;
        qw(1);
        chk("R10 sda_oe after reset", {47'd0, sda_oe}, '0);
        chk("R10 writable regs after reset", wr_regs, '0);

        // Vector table: write one register, read it back through a repeated START
        acks_bad = 1'b0;
        for (int v = 0; v < 8; v++) begin
            bus_start();
            put_byte({ADDR, 1'b0}, a); acks_bad |= a;
            put_byte(VEC[v][23:16], a); acks_bad |= a;
            put_byte(VEC[v][15:8], a); acks_bad |= a;
            bus_stop();
            bus_start();
            put_byte({ADDR, 1'b0}, a); acks_bad |= a;
            put_byte(VEC[v][23:16], a); acks_bad |= a;
            bus_rstart();
            put_byte({ADDR, 1'b1}, a); acks_bad |= a;
            get_byte(1'b0, d);
            bus_stop();
            chk($sformatf("R2 R3 R6 R7 read-back of index %h", VEC[v][23:16]), {40'd0, d}, {40'd0, VEC[v][7:0]});
        end
        chk("R1 R2 R6 R7 every byte acknowledged", {47'd0, acks_bad}, '0);
        chk("R11 writable bus after table", wr_regs, {8'h3C, 8'h00, 8'h81, 8'h00, 8'h01, 8'hA5});

        // Wrong address: no ACK, no register change
        bus_start();
        put_byte({7'h43, 1'b0}, a);
        chk("R1 foreign address not acknowledged", {47'd0, a}, {47'd0, 1'b1});
        put_byte(8'h02, a);
        put_byte(8'h11, b);
        bus_stop();
        chk("R1 no ACK on later bytes", {46'd0, a, b}, {46'd0, 2'b11});
        chk("R1 register untouched by foreign write", {40'd0, wreg(wr_regs, 2)}, {40'd0, 8'hA5});

        // Burst write with auto-increment
        bus_start();
        put_byte({ADDR, 1'b0}, a);
        put_byte(8'h04, a);
        put_byte(8'h11, a);
        put_byte(8'h22, a);
        put_byte(8'h33, b);
        bus_stop();
        chk("R2 burst ACKs", {46'd0, a, b}, '0);
        chk("R2 R11 burst landed at 4..6", {16'd0, wreg(wr_regs, 6), wreg(wr_regs, 5), wreg(wr_regs, 4)},
            {16'd0, 8'h33, 8'h22, 8'h11});

        // Burst read across a repeated START, MSB first
        bus_start();
        put_byte({ADDR, 1'b0}, a);
        put_byte(8'h03, a);
        bus_rstart();
        put_byte({ADDR, 1'b1}, a);
        get_byte(1'b1, d); chk("R3 R9 burst byte 0", {40'd0, d}, {40'd0, 8'h01});
        get_byte(1'b1, d); chk("R3 R9 burst byte 1", {40'd0, d}, {40'd0, 8'h11});
        get_byte(1'b1, d); chk("R3 R9 burst byte 2", {40'd0, d}, {40'd0, 8'h22});
        get_byte(1'b0, d); chk("R3 R9 burst byte 3", {40'd0, d}, {40'd0, 8'h33});
        // After NACK the line stays released while the master keeps clocking
        saved = 8'h00;
        for (int i = 0; i < 8; i++) begin
            get_bit(b);
            saved[i] = b;
        end
        chk("R5 released after master NACK", {40'd0, saved}, {40'd0, 8'hFF});
        bus_stop();

        // Pointer wrap 0xFE -> 0xFF -> 0x00 -> 0x01
        bus_start();
        put_byte({ADDR, 1'b0}, a);
        put_byte(8'hFE, a);
        bus_rstart();
        put_byte({ADDR, 1'b1}, a);
        get_byte(1'b1, d); chk("R7 R8 index FE", {40'd0, d}, {40'd0, 8'h00});
        get_byte(1'b1, d); chk("R7 R8 index FF", {40'd0, d}, {40'd0, 8'h00});
        get_byte(1'b1, d); chk("R6 R8 wrapped to index 0", {40'd0, d}, {40'd0, 8'h81});
        get_byte(1'b0, d); chk("R6 R8 index 1 status", {40'd0, d}, {40'd0, STAT});
        bus_stop();

        // Repeated START in the middle of a data byte
        bus_start();
        put_byte({ADDR, 1'b0}, a);
        put_byte(8'h06, a);
        put_bit(1'b0);
        put_bit(1'b0);
        put_bit(1'b0);
        bus_rstart();
        put_byte({ADDR, 1'b1}, a);
        chk("R4 address after mid-byte START acknowledged", {47'd0, a}, '0);
        get_byte(1'b0, d);
        bus_stop();
        chk("R4 pointer kept, partial byte dropped", {40'd0, d}, {40'd0, 8'h33});
        chk("R4 register 6 unchanged", {40'd0, wreg(wr_regs, 6)}, {40'd0, 8'h33});
        chk("R5 released after STOP", {47'd0, sda_oe}, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule